// File: doc/BRIEF.md
# Three-Axis Lock-In Correlator

This block takes one stream of signed 12-bit converter samples and correlates it at the same time against three signed reference waveforms, one per magnetic field axis. Each reference follows its own axis drive in frequency and phase. Every accepted sample is multiplied by all three references, and each product is added into that axis's own wide accumulator. Together the three accumulators form one demodulated reading per axis.

A frame marker cuts the stream into windows. The marker is normally timed so that every axis window covers a whole number of its own reference periods, and all three windows close at a common 1 kHz rate. When the marker arrives, the three running sums move into output registers in that same clock edge, and the accumulators restart with the sample that comes with the marker. No sample is dropped and no sample is counted twice. A one-cycle strobe announces each new set of results. The first marker after reset only aligns the windows, because the data gathered before it does not cover a full window.

Several channels are served by placing more copies of this block side by side. Each copy handles one converter stream.

Top module: `tri_axis_lockin`

## Requirements
- R1: While `rst` is high at a clock edge, all three results and `res_valid` go to zero after that edge, and the accumulators are cleared.
- R2: At each edge where `smp_valid` is high, the two's complement product `smp_data × ref_a` is added to axis a's accumulator. A cycle with `smp_valid` low adds nothing. This also holds in a marker cycle, where the new window then starts from zero.
- R3: The three axes are independent. Axis X uses only `ref_x`, Y uses only `ref_y`, and Z uses only `ref_z`.
- R4: On an accepted marker (`frame_start` high), each result becomes the sum of products from the previous marker cycle, inclusive, up to the cycle just before this marker. The new value is visible after that edge. The sample presented with the marker is the first sample of the next window.
- R5: `res_valid` is high for exactly the one cycle that follows an accepted marker. Between markers the results hold their values.
- R6: The first marker after reset produces no result and no strobe; the outputs keep their previous values. It only starts the first window.
- R7: A 40-bit accumulator does not wrap within one window of up to 2^20 samples, even at the extreme values −2048 × −128.
- R8: Markers on consecutive cycles each give a strobe. Each such result holds the product of the single sample that came with the marker before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 12 | Signed converter sample |
| ref_x | input | 8 | Signed reference for axis X |
| ref_y | input | 8 | Signed reference for axis Y |
| ref_z | input | 8 | Signed reference for axis Z |
| frame_start | input | 1 | Window boundary marker |
| res_x | output | 40 | Signed result for axis X |
| res_y | output | 40 | Signed result for axis Y |
| res_z | output | 40 | Signed result for axis Z |
| res_valid | output | 1 | One-cycle strobe for new results |

## Verification
Some properties are checked by assertions on every cycle. The strobe only ever follows a marker, and never follows the alignment marker. The results do not move without a commit. A marker cycle with no sample leaves the accumulator at zero. Adding a product never flips the sign of a same-signed accumulator.

The numbers themselves can only be shown by the bench scenarios. These cover the exact sums, the boundary sample falling into the new window, the separation between axes, back-to-back markers and the full range of signed products. The bench sweeps references and samples over their ranges and computes every expected sum arithmetically.

// File: rtl/lockin_pkg.sv
package lockin_pkg;

    localparam int N_AXES = 3;

    typedef enum logic [1:0] {
        AXIS_X = 2'd0,
        AXIS_Y = 2'd1,
        AXIS_Z = 2'd2
    } axis_e;

    typedef struct packed {
        logic armed;
        logic strobe;
    } frame_state_t;

endpackage

// File: rtl/lockin_frame_ctl.sv
module lockin_frame_ctl
    import lockin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    output logic restart,
    output logic commit,
    output logic strobe
);

    frame_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        restart     = frame_start;
        commit      = frame_start && st_q.armed;
        st_d.strobe = commit;
        if (frame_start) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.strobe;

    // R5: a strobe is always preceded by a marker
    assert_strobe_after_marker_R5: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(frame_start));

    // R6: the alignment marker never raises the strobe
    assert_align_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !st_q.armed) |=> !strobe);

endmodule

// File: rtl/lockin_mac_lane.sv
module lockin_mac_lane #(
    parameter int SMP_W = 12,
    parameter int REF_W = 8,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp,
    input  logic signed [REF_W-1:0] refw,
    input  logic                    restart,
    input  logic                    commit,
    output logic signed [ACC_W-1:0] result
);

    localparam int PROD_W = SMP_W + REF_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] res;
    } lane_state_t;

    lane_state_t st_d, st_q;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  contrib;

    always_comb begin
        prod    = smp * refw;
        contrib = smp_valid ? ACC_W'(prod) : '0;
        st_d    = st_q;
        if (restart) begin
            st_d.acc = contrib;
        end else begin
            st_d.acc = st_q.acc + contrib;
        end
        if (commit) begin
            st_d.res = st_q.acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;

    // R2: a marker with no sample starts the window at zero
    assert_empty_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (restart && !smp_valid) |=> (st_q.acc == '0));

    // R5: results hold unless a commit happens
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(result));

    // R7: accumulating a same-signed product never flips the sign
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (!restart && (st_q.acc[ACC_W-1] == contrib[ACC_W-1]))
            |=> (st_q.acc[ACC_W-1] == $past(st_q.acc[ACC_W-1])));

endmodule

// File: rtl/tri_axis_lockin.sv
module tri_axis_lockin
    import lockin_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int REF_W = 8,
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic signed [REF_W-1:0] ref_x,
    input  logic signed [REF_W-1:0] ref_y,
    input  logic signed [REF_W-1:0] ref_z,
    input  logic                    frame_start,
    output logic signed [ACC_W-1:0] res_x,
    output logic signed [ACC_W-1:0] res_y,
    output logic signed [ACC_W-1:0] res_z,
    output logic                    res_valid
);

    logic restart;
    logic commit;
    logic [N_AXES-1:0][REF_W-1:0] refs;
    logic [N_AXES-1:0][ACC_W-1:0] results;

    assign refs[AXIS_X] = ref_x;
    assign refs[AXIS_Y] = ref_y;
    assign refs[AXIS_Z] = ref_z;

    lockin_frame_ctl u_frame (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .restart     (restart),
        .commit      (commit),
        .strobe      (res_valid)
    );

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        lockin_mac_lane #(
            .SMP_W (SMP_W),
            .REF_W (REF_W),
            .ACC_W (ACC_W)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .smp_valid (smp_valid),
            .smp       (smp_data),
            .refw      (signed'(refs[a])),
            .restart   (restart),
            .commit    (commit),
            .result    (results[a])
        );
    end

    assign res_x = signed'(results[AXIS_X]);
    assign res_y = signed'(results[AXIS_Y]);
    assign res_z = signed'(results[AXIS_Z]);

    // R1: one cycle after reset, everything is at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && res_x == '0 && res_y == '0 && res_z == '0));

endmodule

// File: tb/tri_axis_lockin_test.sv
module tri_axis_lockin_test;

    localparam int CLK_P = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic signed [11:0] smp_data = '0;
    logic signed [7:0]  ref_x = '0, ref_y = '0, ref_z = '0;
    logic               frame_start = 1'b0;
    logic signed [39:0] res_x, res_y, res_z;
    logic               res_valid;

    int n_cmp = 0;
    int n_bad = 0;

    longint acc_m [3];
    longint last_m [3];
    bit     armed_m = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tri_axis_lockin uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .ref_x(ref_x), .ref_y(ref_y), .ref_z(ref_z), .frame_start(frame_start),
        .res_x(res_x), .res_y(res_y), .res_z(res_z), .res_valid(res_valid)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint outv(input int a);
        case (a)
            0: return longint'(res_x);
            1: return longint'(res_y);
            default: return longint'(res_z);
        endcase
    endfunction

    task automatic reset_seq();
        @(negedge clk);
        rst = 1'b1; frame_start = 1'b0; smp_valid = 1'b1; smp_data = 12'sd700;
        ref_x = 8'sd5; ref_y = 8'sd6; ref_z = 8'sd7;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs cleared while in reset
        chk("R1 res_valid", longint'(res_valid), 0);
        for (int a = 0; a < 3; a++) chk("R1 result", outv(a), 0);
        for (int a = 0; a < 3; a++) begin acc_m[a] = 0; last_m[a] = 0; end
        armed_m = 1'b0;
        @(negedge clk);
        rst = 1'b0; smp_valid = 1'b0;
    endtask

    task automatic cyc(input bit fs, input bit v, input int s,
                       input int rx, input int ry, input int rz);
        longint p [3];
        bit exp_v;
        @(negedge clk);
        frame_start = fs; smp_valid = v; smp_data = 12'(s);
        ref_x = 8'(rx); ref_y = 8'(ry); ref_z = 8'(rz);
        p[0] = v ? longint'(s) * longint'(rx) : 0;
        p[1] = v ? longint'(s) * longint'(ry) : 0;
        p[2] = v ? longint'(s) * longint'(rz) : 0;
        exp_v = 1'b0;
        if (fs) begin
            if (armed_m) begin
                exp_v = 1'b1;
                for (int a = 0; a < 3; a++) last_m[a] = acc_m[a];
            end
            armed_m = 1'b1;
            for (int a = 0; a < 3; a++) acc_m[a] = p[a];
        end else begin
            for (int a = 0; a < 3; a++) acc_m[a] += p[a];
        end
        @(posedge clk);
        #1;
        // R5/R6: strobe only after an accepted marker
        chk("R5/R6 res_valid", longint'(res_valid), longint'(exp_v));
        // R4/R3: per-axis sums (hold values when no strobe, R5)
        for (int a = 0; a < 3; a++)
            chk(exp_v ? "R4 R3 axis result" : "R5 held result", outv(a), last_m[a]);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        reset_seq();

        // R6: data before the first marker is discarded, no strobe
        for (int i = 0; i < 20; i++) cyc(0, 1, 1000 - i, 100, -100, 50);
        cyc(1, 1, 3, 2, 3, 4);
        for (int i = 0; i < 10; i++) cyc(0, 1, i, 1, 2, 3);

        // R2 R3 R4: sweep references and samples, with gaps in smp_valid
        for (int rr = -128; rr <= 124; rr += 4) begin
            for (int i = 0; i < 512; i++) begin
                cyc(i == 0, (i % 7) != 3, -2048 + 8 * i, rr, -rr - 1,
                    ((i * 37 + rr) & 255) - 128);
            end
        end

        // R2: marker cycle without a sample starts the window at zero
        cyc(1, 0, 1234, 100, 100, 100);
        for (int i = 0; i < 5; i++) cyc(0, (i % 2) == 0, 17 * i - 40, -3, 9, 127);

        // R7: extreme products over a long window
        cyc(1, 1, -2048, -128, 127, -128);
        for (int i = 0; i < 3000; i++) cyc(0, 1, -2048, -128, 127, -128);
        cyc(1, 1, 2047, -128, -128, 127);
        for (int i = 0; i < 3000; i++) cyc(0, 1, 2047, -128, -128, 127);

        // R8: back-to-back markers give single-sample results
        for (int i = 0; i < 5; i++) cyc(1, 1, 100 * i - 300, 7 - i, -i, i * 11);
        cyc(1, 0, 0, 0, 0, 0);

        // R1 R6: reset mid-run, then alignment again
        for (int i = 0; i < 8; i++) cyc(0, 1, 500, 50, 60, 70);
        reset_seq();
        for (int i = 0; i < 6; i++) cyc(0, 1, -9, 4, 4, 4);
        cyc(1, 1, 11, -1, 1, -2);
        for (int i = 0; i < 6; i++) cyc(0, 1, 2 * i, 3, -3, 5);
        cyc(1, 0, 0, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule